// File: doc/BRIEF.md
# Mode-Filtered Event Counter with Overflow Interrupt

This block is one programmable hardware event counter and the 64-bit control word that steers it. Software uses a simple register port to read and write both the control word and the counter value. The control word picks which of a vector of single-cycle event strobes advances the counter. It also carries one inhibit bit per privilege mode, covering the virtualized supervisor and user modes, so that counting stops while the hart runs in a chosen mode.

When the counter wraps past its all-ones value, a sticky overflow flag in the control word is set. The wrap raises a one-cycle interrupt request only if that flag was clear beforehand. Once the flag is set, later wraps stay silent until software clears it.

Written event codes are legalized before they are stored. Inhibit bits for modes the hart does not implement are tied to zero. A parameter can switch the whole counter off, which leaves every field read-only at zero.

Top module: `hpm_event_counter`

## Requirements
- R1: After a synchronous reset, the control word and the counter are zero, `ovf_irq` is low and `csr_rdata` is zero.
- R2: `csr_rdata` is registered. After each clock edge it holds the register that `csr_sel` chose in the cycle before that edge, as that register stood before the edge. `csr_sel`=0 selects the control word and `csr_sel`=1 selects the counter, zero-extended to 64 bits.
- R3: When the control word's event code is k, with 1 <= k <= NUM_EVT, the counter advances by one on every clock where `evt_strobe[k-1]` is high and no inhibit applies. Event code 0 never counts, and a strobe on any other bit has no effect.
- R4: Control bits select the inhibited modes: bit 62 inhibits machine mode, bit 61 supervisor, bit 60 user, bit 59 virtual supervisor and bit 58 virtual user. `priv_mode` is encoded as 0=user, 1=supervisor, 3=machine, and 2 is treated as machine. With `virt_mode`=1, supervisor is read as virtual supervisor and user as virtual user. Machine mode ignores `virt_mode`.
- R5: A written event code (bits 57:0) is stored only if it lies in 1..NUM_EVT and its bit in EVT_SUPPORTED (bit k-1 for code k) is set. Any other written code is stored as 0.
- R6: A control write stores the overflow flag (bit 63) and the implemented inhibit bits exactly as written. The new value is visible from the next clock.
- R7: An increment from all ones wraps the counter to zero and sets the overflow flag, and the flag stays set until a control write changes it. `ovf_irq` pulses high for exactly the one cycle after the wrap, and only if the flag was clear when the wrap happened.
- R8: If a control write and a wrap fall in the same cycle, the flag ends up set, whatever value the write carried for bit 63.
- R9: A counter write (`csr_we`=1, `csr_sel`=1) loads the low CNT_W bits of `csr_wdata`. It takes priority over an increment in the same cycle, and in that case no wrap occurs.
- R10: The supervisor inhibit bit is writable only if HAS_S is set, the user inhibit bit only if HAS_U is set, and the two virtual-mode bits only if HAS_H is set. Otherwise these bits read zero.
- R11: With COUNTER_EN=0, every control field and the counter read zero, and all writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Software write strobe |
| csr_sel | input | 1 | Register select: 0 control word, 1 counter |
| csr_wdata | input | 64 | Software write data |
| csr_rdata | output | 64 | Registered read data |
| evt_strobe | input | NUM_EVT | Single-cycle event strobes; bit k-1 is event code k |
| priv_mode | input | 2 | Current privilege mode (0 user, 1 supervisor, 3 machine) |
| virt_mode | input | 1 | Hart is running virtualized |
| ovf_irq | output | 1 | One-cycle overflow interrupt request |

## Verification
A corrupted event field or inhibit bit shows on the next counter read as a missing or extra increment. It also appears one cycle after any read of the control word. A wrong overflow flag shows in two ways: as a missing or duplicated `ovf_irq` pulse on the very next wrap, and as a wrong bit 63 on the following control read. Because reads are registered, every discrepancy reaches `csr_rdata` exactly one clock after the cycle that selected the register, so a fault is seen within two cycles of being provoked.

// File: rtl/hpmc_pkg.sv
package hpmc_pkg;

  localparam int CTRL_W = 64;
  localparam int CODE_W = 58;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  // Field order fixes bit positions: ovf at 63 down to code at 57:0
  typedef struct packed {
    logic              ovf;
    logic              inh_m;
    logic              inh_s;
    logic              inh_u;
    logic              inh_vs;
    logic              inh_vu;
    logic [CODE_W-1:0] code;
  } hpmc_ctrl_t;

endpackage

// File: rtl/hpmc_ctrl_reg.sv
module hpmc_ctrl_reg
  import hpmc_pkg::*;
#(
  parameter int                 NUM_EVT       = 8,
  parameter logic [NUM_EVT-1:0] EVT_SUPPORTED = '1,
  parameter bit                 COUNTER_EN    = 1'b1,
  parameter bit                 HAS_S         = 1'b1,
  parameter bit                 HAS_U         = 1'b1,
  parameter bit                 HAS_H         = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              hw_ovf_set,
  output hpmc_ctrl_t        ctrl_q
);

  hpmc_ctrl_t        wr_fields;
  logic [CODE_W-1:0] legal_code;
  logic              wr_ok;
  logic              set_ok;

  assign wr_fields = hpmc_ctrl_t'(wr_data);
  assign wr_ok     = wr_en && COUNTER_EN;
  assign set_ok    = hw_ovf_set && COUNTER_EN;

  // Keep a code only when it names a supported strobe; anything else becomes "no event"
  always_comb begin
    legal_code = '0;
    for (int k = 1; k <= NUM_EVT; k++) begin
      if (wr_fields.code == CODE_W'(k) && EVT_SUPPORTED[k-1]) begin
        legal_code = wr_fields.code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ok) begin
        ctrl_q.ovf    <= wr_fields.ovf;
        ctrl_q.inh_m  <= wr_fields.inh_m;
        ctrl_q.inh_s  <= HAS_S ? wr_fields.inh_s  : 1'b0;
        ctrl_q.inh_u  <= HAS_U ? wr_fields.inh_u  : 1'b0;
        ctrl_q.inh_vs <= HAS_H ? wr_fields.inh_vs : 1'b0;
        ctrl_q.inh_vu <= HAS_H ? wr_fields.inh_vu : 1'b0;
        ctrl_q.code   <= legal_code;
      end
      // A hardware wrap overrides a software value written in the same cycle
      if (set_ok) begin
        ctrl_q.ovf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hpmc_mode_filter.sv
module hpmc_mode_filter
  import hpmc_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [4:0]         inh,        // {m, s, u, vs, vu}
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [1:0]         priv_mode,
  input  logic               virt_mode,
  output logic               count_en
);

  logic hit;
  logic blocked;

  always_comb begin
    hit = 1'b0;
    for (int k = 1; k <= NUM_EVT; k++) begin
      if (code == CODE_W'(k) && evt_strobe[k-1]) begin
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (priv_e'(priv_mode))
      PRIV_U:  blocked = virt_mode ? inh[0] : inh[2];
      PRIV_S:  blocked = virt_mode ? inh[1] : inh[3];
      default: blocked = inh[4];
    endcase
  end

  assign count_en = hit && !blocked;

endmodule

// File: rtl/hpmc_counter.sv
module hpmc_counter #(
  parameter int CNT_W      = 16,
  parameter bit COUNTER_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_flag,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             irq_q
);

  logic wr_ok;
  logic step;

  assign wr_ok = wr_en && COUNTER_EN;
  assign step  = inc && !wr_ok && COUNTER_EN;
  assign wrap  = step && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        cnt_q <= wr_data;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
      irq_q <= wrap && !ovf_flag;
    end
  end

endmodule

// File: rtl/hpm_event_counter.sv
module hpm_event_counter
  import hpmc_pkg::*;
#(
  parameter int                 CNT_W         = 16,
  parameter int                 NUM_EVT       = 8,
  parameter logic [NUM_EVT-1:0] EVT_SUPPORTED = 8'h7F,
  parameter bit                 COUNTER_EN    = 1'b1,
  parameter bit                 HAS_S         = 1'b1,
  parameter bit                 HAS_U         = 1'b1,
  parameter bit                 HAS_H         = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_we,
  input  logic               csr_sel,
  input  logic [63:0]        csr_wdata,
  output logic [63:0]        csr_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [1:0]         priv_mode,
  input  logic               virt_mode,
  output logic               ovf_irq
);

  hpmc_ctrl_t       ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr_en;
  logic             cnt_wr_en;
  logic             count_en;
  logic             wrap;

  assign ctrl_wr_en = csr_we && !csr_sel;
  assign cnt_wr_en  = csr_we && csr_sel;

  hpmc_ctrl_reg #(
    .NUM_EVT       (NUM_EVT),
    .EVT_SUPPORTED (EVT_SUPPORTED),
    .COUNTER_EN    (COUNTER_EN),
    .HAS_S         (HAS_S),
    .HAS_U         (HAS_U),
    .HAS_H         (HAS_H)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctrl_wr_en),
    .wr_data    (csr_wdata),
    .hw_ovf_set (wrap),
    .ctrl_q     (ctrl_q)
  );

  hpmc_mode_filter #(
    .NUM_EVT (NUM_EVT)
  ) u_filter (
    .code       (ctrl_q.code),
    .inh        ({ctrl_q.inh_m, ctrl_q.inh_s, ctrl_q.inh_u, ctrl_q.inh_vs, ctrl_q.inh_vu}),
    .evt_strobe (evt_strobe),
    .priv_mode  (priv_mode),
    .virt_mode  (virt_mode),
    .count_en   (count_en)
  );

  hpmc_counter #(
    .CNT_W      (CNT_W),
    .COUNTER_EN (COUNTER_EN)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inc      (count_en),
    .wr_en    (cnt_wr_en),
    .wr_data  (csr_wdata[CNT_W-1:0]),
    .ovf_flag (ctrl_q.ovf),
    .cnt_q    (cnt_q),
    .wrap     (wrap),
    .irq_q    (ovf_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else begin
      csr_rdata <= csr_sel ? 64'(cnt_q) : 64'(ctrl_q);
    end
  end

endmodule

// File: rtl/hpmc_checker.sv
module hpmc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic [1:0]       priv_mode,
  input logic             of_flag,
  input logic             inh_m,
  input logic             ovf_irq,
  input logic [CNT_W-1:0] cnt
);

  // R7: request lasts a single cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |=> !ovf_irq);

  // R7: a request comes with the flag now set
  p_irq_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> of_flag);

  // R7: no request when the flag was already set
  p_no_irq_when_set_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> !$past(of_flag));

  // R7: the flag is sticky without a control write
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (of_flag && !ctrl_wr) |=> of_flag);

  // R3: at most one step per clock unless software loads the counter
  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R4: machine-mode inhibit freezes the counter
  p_inhibit_m_r4: assert property (@(posedge clk) disable iff (rst)
    (priv_mode == 2'b11 && inh_m && !cnt_wr) |=> $stable(cnt));

endmodule

bind hpm_event_counter hpmc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_wr   (ctrl_wr_en),
  .cnt_wr    (cnt_wr_en),
  .priv_mode (priv_mode),
  .of_flag   (ctrl_q.ovf),
  .inh_m     (ctrl_q.inh_m),
  .ovf_irq   (ovf_irq),
  .cnt       (cnt_q)
);

// File: tb/tb_hpm_event_counter.sv
`timescale 1ns/1ps
module tb_hpm_event_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic        csr_sel = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [7:0]  evt_strobe = '0;
  logic [1:0]  priv_mode = 2'd3;
  logic        virt_mode = 1'b0;
  logic [63:0] rd, rd_noext, rd_off;
  logic        irq, irq_noext, irq_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  hpm_event_counter dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(rd), .evt_strobe(evt_strobe), .priv_mode(priv_mode),
    .virt_mode(virt_mode), .ovf_irq(irq));

  hpm_event_counter #(.HAS_S(1'b0), .HAS_U(1'b0), .HAS_H(1'b0)) dut_noext (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(rd_noext), .evt_strobe(evt_strobe), .priv_mode(priv_mode),
    .virt_mode(virt_mode), .ovf_irq(irq_noext));

  hpm_event_counter #(.COUNTER_EN(1'b0)) dut_off (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(rd_off), .evt_strobe(evt_strobe), .priv_mode(priv_mode),
    .virt_mode(virt_mode), .ovf_irq(irq_off));

  typedef struct packed {
    logic        we;
    logic        sel;
    logic [63:0] wd;
    logic [7:0]  evt;
    logic [1:0]  mode;
    logic        virt;
    logic [63:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  // Each vector is applied for one cycle; expectations are sampled after that edge.
  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,64'h0,                  8'h00,2'd3,1'b0,64'h0,                  1'b0,4'd1},  // R1 reset
    '{1'b1,1'b0,64'h1,                  8'h00,2'd3,1'b0,64'h0,                  1'b0,4'd2},  // R2 select code 1
    '{1'b0,1'b0,64'h0,                  8'h01,2'd3,1'b0,64'h1,                  1'b0,4'd2},  // R2 ctrl read, R3 count
    '{1'b0,1'b1,64'h0,                  8'h01,2'd0,1'b0,64'h1,                  1'b0,4'd3},  // R3
    '{1'b0,1'b1,64'h0,                  8'h02,2'd0,1'b0,64'h2,                  1'b0,4'd3},  // R3 other strobe
    '{1'b0,1'b1,64'h0,                  8'h00,2'd0,1'b0,64'h2,                  1'b0,4'd3},  // R3
    '{1'b1,1'b0,64'h4000_0000_0000_0001,8'h01,2'd3,1'b0,64'h1,                  1'b0,4'd6},  // R6 set M inhibit
    '{1'b0,1'b1,64'h0,                  8'h01,2'd3,1'b0,64'h3,                  1'b0,4'd4},  // R4 M blocked
    '{1'b0,1'b1,64'h0,                  8'h01,2'd1,1'b0,64'h3,                  1'b0,4'd4},  // R4 S counts
    '{1'b0,1'b1,64'h0,                  8'h01,2'd0,1'b1,64'h4,                  1'b0,4'd4},  // R4 VU counts
    '{1'b1,1'b0,64'h3C00_0000_0000_0001,8'h01,2'd3,1'b0,64'h4000_0000_0000_0001,1'b0,4'd6},  // R6
    '{1'b0,1'b1,64'h0,                  8'h01,2'd1,1'b0,64'h5,                  1'b0,4'd4},  // R4 S blocked
    '{1'b0,1'b1,64'h0,                  8'h01,2'd0,1'b0,64'h5,                  1'b0,4'd4},  // R4 U blocked
    '{1'b0,1'b1,64'h0,                  8'h01,2'd1,1'b1,64'h5,                  1'b0,4'd4},  // R4 VS blocked
    '{1'b0,1'b1,64'h0,                  8'h01,2'd0,1'b1,64'h5,                  1'b0,4'd4},  // R4 VU blocked
    '{1'b0,1'b1,64'h0,                  8'h01,2'd3,1'b0,64'h5,                  1'b0,4'd4},  // R4 M counts
    '{1'b0,1'b1,64'h0,                  8'h00,2'd3,1'b0,64'h6,                  1'b0,4'd4},  // R4
    '{1'b1,1'b0,64'h5,                  8'h00,2'd3,1'b0,64'h3C00_0000_0000_0001,1'b0,4'd6},  // R6 readback
    '{1'b0,1'b0,64'h0,                  8'h00,2'd3,1'b0,64'h5,                  1'b0,4'd5},  // R5 code 5 kept
    '{1'b1,1'b0,64'h4000_0000_0000_0008,8'h00,2'd3,1'b0,64'h5,                  1'b0,4'd5},  // R5
    '{1'b0,1'b0,64'h0,                  8'h00,2'd3,1'b0,64'h4000_0000_0000_0000,1'b0,4'd5},  // R5 code 8 unsupported
    '{1'b1,1'b0,64'h100,                8'h00,2'd3,1'b0,64'h4000_0000_0000_0000,1'b0,4'd5},  // R5
    '{1'b0,1'b0,64'h0,                  8'h00,2'd3,1'b0,64'h0,                  1'b0,4'd5},  // R5 code 256 out of range
    '{1'b1,1'b0,64'h3,                  8'h00,2'd3,1'b0,64'h0,                  1'b0,4'd5},  // R5
    '{1'b1,1'b1,64'hFFFF,               8'h00,2'd3,1'b0,64'h6,                  1'b0,4'd9},  // R9 load
    '{1'b0,1'b1,64'h0,                  8'h04,2'd0,1'b0,64'hFFFF,               1'b1,4'd7},  // R7 wrap, irq
    '{1'b0,1'b0,64'h0,                  8'h00,2'd0,1'b0,64'h8000_0000_0000_0003,1'b0,4'd7},  // R7 flag set, pulse ends
    '{1'b1,1'b1,64'hFFFF,               8'h00,2'd0,1'b0,64'h0,                  1'b0,4'd7},  // R7 wrapped to 0
    '{1'b0,1'b1,64'h0,                  8'h04,2'd0,1'b0,64'hFFFF,               1'b0,4'd7},  // R7 no irq, flag set
    '{1'b0,1'b0,64'h0,                  8'h00,2'd0,1'b0,64'h8000_0000_0000_0003,1'b0,4'd7},  // R7 sticky
    '{1'b1,1'b0,64'h3,                  8'h00,2'd0,1'b0,64'h8000_0000_0000_0003,1'b0,4'd6},  // R6 clear flag
    '{1'b1,1'b1,64'hFFFF,               8'h00,2'd0,1'b0,64'h0,                  1'b0,4'd9},  // R9
    '{1'b1,1'b0,64'h3,                  8'h04,2'd0,1'b0,64'h3,                  1'b1,4'd8},  // R8 write vs wrap
    '{1'b0,1'b0,64'h0,                  8'h00,2'd0,1'b0,64'h8000_0000_0000_0003,1'b0,4'd8},  // R8 hw set wins
    '{1'b1,1'b1,64'h10,                 8'h04,2'd0,1'b0,64'h0,                  1'b0,4'd9},  // R9 write beats inc
    '{1'b0,1'b1,64'h0,                  8'h00,2'd0,1'b0,64'h10,                 1'b0,4'd9},  // R9
    '{1'b1,1'b1,64'hABCD_0000_0000_1234,8'h00,2'd0,1'b0,64'h10,                 1'b0,4'd9},  // R9
    '{1'b0,1'b1,64'h0,                  8'h00,2'd0,1'b0,64'h1234,               1'b0,4'd9},  // R9 truncated
    '{1'b1,1'b0,64'h8000_0000_0000_0000,8'h00,2'd0,1'b0,64'h8000_0000_0000_0003,1'b0,4'd6},  // R6
    '{1'b0,1'b0,64'h0,                  8'h00,2'd0,1'b0,64'h8000_0000_0000_0000,1'b0,4'd6},  // R6 flag written 1
    '{1'b1,1'b0,64'h4000_0000_0000_0001,8'h00,2'd0,1'b0,64'h8000_0000_0000_0000,1'b0,4'd4},  // R4
    '{1'b0,1'b1,64'h0,                  8'h01,2'd2,1'b0,64'h1234,               1'b0,4'd4},  // R4 mode 2 as M
    '{1'b0,1'b1,64'h0,                  8'h00,2'd2,1'b0,64'h1234,               1'b0,4'd4},  // R4
    '{1'b0,1'b1,64'h0,                  8'h01,2'd3,1'b1,64'h1234,               1'b0,4'd4},  // R4 M ignores virt
    '{1'b0,1'b1,64'h0,                  8'h00,2'd3,1'b0,64'h1234,               1'b0,4'd4}   // R4
  };

  task automatic cyc(input logic we, input logic sel, input logic [63:0] wd,
                     input logic [7:0] ev, input logic [1:0] md, input logic vt);
    csr_we = we; csr_sel = sel; csr_wdata = wd;
    evt_strobe = ev; priv_mode = md; virt_mode = vt;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(4.0 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc(1'b0, 1'b0, 64'h0, 8'h00, 2'd3, 1'b0);
    cyc(1'b0, 1'b0, 64'h0, 8'h00, 2'd3, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].we, VECS[i].sel, VECS[i].wd, VECS[i].evt, VECS[i].mode, VECS[i].virt);
      check64($sformatf("R%0d vec %0d rdata", VECS[i].req, i), rd, VECS[i].exp_rd);
      check64($sformatf("R%0d vec %0d irq", VECS[i].req, i), 64'(irq), 64'(VECS[i].exp_irq));
    end

    // R10: optional-mode inhibit bits are tied to zero
    cyc(1'b1, 1'b0, 64'hFC00_0000_0000_0001, 8'h00, 2'd3, 1'b0);
    cyc(1'b0, 1'b0, 64'h0, 8'h00, 2'd3, 1'b0);
    check64("R10 noext ctrl", rd_noext, 64'hC000_0000_0000_0001);
    check64("R6 full ctrl", rd, 64'hFC00_0000_0000_0001);

    // R11: disabled counter ignores writes and reads zero
    check64("R11 off ctrl", rd_off, 64'h0);
    cyc(1'b1, 1'b1, 64'h55, 8'h00, 2'd3, 1'b0);
    cyc(1'b0, 1'b1, 64'h0, 8'h00, 2'd3, 1'b0);
    check64("R11 off counter", rd_off, 64'h0);
    check64("R11 off irq", 64'(irq_off), 64'h0);

    // R1: mid-run reset clears state
    cyc(1'b1, 1'b1, 64'h77, 8'h00, 2'd3, 1'b0);
    rst = 1'b1;
    cyc(1'b0, 1'b1, 64'h0, 8'h00, 2'd3, 1'b0);
    check64("R1 rdata in reset", rd, 64'h0);
    rst = 1'b0;
    cyc(1'b0, 1'b1, 64'h0, 8'h00, 2'd3, 1'b0);
    check64("R1 counter after reset", rd, 64'h0);
    check64("R1 irq after reset", 64'(irq), 64'h0);
    cyc(1'b0, 1'b0, 64'h0, 8'h00, 2'd3, 1'b0);
    check64("R1 ctrl after reset", rd, 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule